// File: doc/BRIEF.md
# Synchronous SRAM Port Burst Address Counter

This block is the address front end of one port of a synchronous SRAM, together with a small word array so that accesses can be observed. On each rising clock edge an internal word counter either loads the external address, steps by one, or holds. The counter's current value is the address that the array uses in that cycle, and it also appears on an output.

The counter is controlled only by the clock, an active-low address strobe and an active-low count enable. The two chip enable inputs decide whether the current cycle performs an access. They have no effect on the counter. If a burst enables the chip only on alternate cycles while counting continues, every other word is accessed.

The data path has no back-pressure. `wdata` is taken whenever a write access happens. `rdata` is qualified by `rd_valid`, which must be consumed in the cycle it is high because nothing holds it. Control pins are plain levels sampled on the clock.

Top module: `sram_burst_port`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `int_addr` is 0, `acc_valid` is 0 whatever the chip enables show, and `rd_valid` is 0.
- R2: If `adr_stb_n` is low at a rising edge, `int_addr` equals the `ext_addr` sampled at that edge for the whole following cycle.
- R3: If `adr_stb_n` is high and `cnt_en_n` is low at a rising edge, `int_addr` becomes its previous value plus one.
- R4: If both `adr_stb_n` and `cnt_en_n` are high at a rising edge, `int_addr` keeps its value.
- R5: If `adr_stb_n` and `cnt_en_n` are both low at an edge, the load wins and `int_addr` becomes `ext_addr`.
- R6: Counting up from the all-ones address (63 by default) gives address 0.
- R7: The chip enables do not change how the counter updates. It loads, counts or holds the same way with the chip enabled or disabled.
- R8: `acc_valid` is high exactly when `ce0_n` is low and `ce1` is high, outside reset.
- R9: A write (`wr_en`=1) stores `wdata` at the current `int_addr` at the cycle's closing edge, and only if `acc_valid` is high. With the chip disabled the array is unchanged.
- R10: A read (`acc_valid`=1, `wr_en`=0) gives the word at that cycle's `int_addr` on `rdata`, with `rd_valid`=1, in the next cycle. `rd_valid` is 0 after any cycle without a read.
- R11: After a load of address A with counting held on, enabling the chip only in the 2nd, 4th and 6th cycles after the load cycle reads addresses A+1, A+3 and A+5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | ADDR_W | Address loaded by the strobe |
| adr_stb_n | input | 1 | Active-low address load strobe |
| cnt_en_n | input | 1 | Active-low count enable |
| ce0_n | input | 1 | Active-low chip enable |
| ce1 | input | 1 | Active-high chip enable |
| wr_en | input | 1 | 1 = write, 0 = read |
| wdata | input | DATA_W | Write data |
| acc_valid | output | 1 | This cycle performs an access |
| int_addr | output | ADDR_W | Current internal word address |
| rdata | output | DATA_W | Read data, one cycle after the read |
| rd_valid | output | 1 | Qualifies rdata |

## Verification
The hardest case to reach is a burst in which the counter keeps stepping while the chip is disabled. Only the words actually accessed show that the counter ignored the chip enables. The bench first fills the array with address-tagged words. It then loads a start address, keeps counting enabled and toggles the chip enables every cycle. Each returned word must carry the odd offset, and a skipped word at an even offset would give itself away. A write attempted with the chip disabled is checked the same way, by reading that word back later and expecting its earlier contents.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
  typedef enum logic [1:0] {
    CTR_HOLD = 2'd0,
    CTR_LOAD = 2'd1,
    CTR_STEP = 2'd2
  } ctr_op_e;

  function automatic ctr_op_e pick_ctr_op(input logic stb_n, input logic cen_n);
    if (!stb_n)     return CTR_LOAD;
    else if (!cen_n) return CTR_STEP;
    else             return CTR_HOLD;
  endfunction
endpackage

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              adr_stb_n,
  input  logic              cnt_en_n,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

  ctr_op_e           op;
  logic [ADDR_W-1:0] nxt_addr;

  always_comb begin
    op = pick_ctr_op(adr_stb_n, cnt_en_n);
    unique case (op)
      CTR_LOAD: nxt_addr = ext_addr;
      CTR_STEP: nxt_addr = cur_addr + ONE;
      default:  nxt_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_addr <= '0;
    else        cur_addr <= nxt_addr;
  end

  // Marks edges whose previous edge was already out of reset.
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!adr_stb_n)) |-> (cur_addr == $past(ext_addr)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(adr_stb_n && !cnt_en_n)) |-> (cur_addr == $past(cur_addr) + ONE));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(adr_stb_n && cnt_en_n)) |-> $stable(cur_addr));

  p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!adr_stb_n && !cnt_en_n)) |-> (cur_addr == $past(ext_addr)));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(adr_stb_n && !cnt_en_n && cur_addr == TOP_ADDR)) |-> (cur_addr == '0));
endmodule

// File: rtl/access_gate.sv
module access_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ce0_n,
  input  logic ce1,
  input  logic wr_en,
  output logic acc_valid,
  output logic wr_stb,
  output logic rd_stb,
  output logic rd_valid
);
  logic chip_on;

  always_comb begin
    chip_on   = !ce0_n && ce1;
    acc_valid = chip_on && rst_n;
    wr_stb    = acc_valid && wr_en;
    rd_stb    = acc_valid && !wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_stb;
  end

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_rdv_follows_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (rd_valid == $past(!ce0_n && ce1 && !wr_en)));

  p_no_access_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce0_n || !ce1) |-> !(wr_stb || rd_stb));
endmodule

// File: rtl/word_array.sv
module word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_stb) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_stb) rdata <= mem[addr];
  end
endmodule

// File: rtl/sram_burst_port.sv
module sram_burst_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              adr_stb_n,
  input  logic              cnt_en_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] int_addr,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  logic wr_stb;
  logic rd_stb;

  burst_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .adr_stb_n (adr_stb_n),
    .cnt_en_n  (cnt_en_n),
    .cur_addr  (int_addr)
  );

  access_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce0_n     (ce0_n),
    .ce1       (ce1),
    .wr_en     (wr_en),
    .acc_valid (acc_valid),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .rd_valid  (rd_valid)
  );

  word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (int_addr),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .wdata  (wdata),
    .rdata  (rdata)
  );

  // R7: the counter ignores the chip enables, so a disabled cycle still counts.
  p_count_while_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_stb_n && !cnt_en_n && (ce0_n || !ce1)) |=> (int_addr == $past(int_addr) + ADDR_W'(1)));
endmodule

// File: tb/sram_burst_port_tb.sv
module sram_burst_port_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] ext_addr = '0;
  logic              adr_stb_n = 1'b1;
  logic              cnt_en_n = 1'b1;
  logic              ce0_n = 1'b1;
  logic              ce1 = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic              acc_valid;
  logic [ADDR_W-1:0] int_addr;
  logic [DATA_W-1:0] rdata;
  logic              rd_valid;

  int n_run = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sram_burst_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .adr_stb_n(adr_stb_n),
    .cnt_en_n(cnt_en_n), .ce0_n(ce0_n), .ce1(ce1), .wr_en(wr_en), .wdata(wdata),
    .acc_valid(acc_valid), .int_addr(int_addr), .rdata(rdata), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; this advances one full cycle.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic stb_n, input logic cen_n, input logic en,
                       input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    adr_stb_n = stb_n;
    cnt_en_n  = cen_n;
    ce0_n     = !en;
    ce1       = en;
    wr_en     = wr;
    ext_addr  = a;
    wdata     = d;
  endtask

  task automatic t_reset();
    drive(1'b0, 1'b0, 1'b1, 1'b0, 6'd17, 16'h0);
    #1;
    check("R1 addr in reset", 32'(int_addr), 0);
    check("R1 acc_valid in reset", 32'(acc_valid), 0);
    check("R1 rd_valid in reset", 32'(rd_valid), 0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 16'h0);
    rst_n = 1'b1;
    tick();
    check("R1 addr after reset", 32'(int_addr), 0);
    check("R1 rd_valid after reset", 32'(rd_valid), 0);
  endtask

  task automatic t_load_step_hold();
    drive(1'b0, 1'b1, 1'b0, 1'b0, 6'd10, 16'h0);
    tick();
    check("R2 loaded", 32'(int_addr), 10);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 6'd33, 16'h0);
    tick();
    check("R3 step 1", 32'(int_addr), 11);
    tick();
    check("R3 step 2", 32'(int_addr), 12);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd33, 16'h0);
    tick();
    tick();
    check("R4 hold", 32'(int_addr), 12);
  endtask

  task automatic t_priority_wrap();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 6'd40, 16'h0);
    tick();
    check("R5 load wins", 32'(int_addr), 40);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 6'd63, 16'h0);
    tick();
    check("R6 at top", 32'(int_addr), 63);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 6'd5, 16'h0);
    tick();
    check("R6 wrapped", 32'(int_addr), 0);
  endtask

  task automatic t_ce_independent();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 6'd20, 16'h0);
    #1;
    check("R8 acc_valid on", 32'(acc_valid), 1);
    tick();
    check("R7 load with chip on", 32'(int_addr), 20);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 16'h0);
    #1;
    check("R8 acc_valid off", 32'(acc_valid), 0);
    ce0_n = 1'b0; ce1 = 1'b0;
    #1;
    check("R8 only one enable", 32'(acc_valid), 0);
    tick();
    tick();
    check("R7 counts with chip off", 32'(int_addr), 22);
  endtask

  task automatic t_write_read();
    // Write 0xA000+k at addresses 20..24.
    drive(1'b0, 1'b1, 1'b0, 1'b0, 6'd20, 16'h0);
    tick();
    for (int k = 0; k < 5; k++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b1, 6'd0, 16'(16'hA000 + k));
      tick();
    end
    // Try to overwrite 22 with the chip disabled.
    drive(1'b0, 1'b1, 1'b0, 1'b0, 6'd22, 16'h0);
    tick();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 6'd0, 16'hDEAD);
    tick();
    check("R9 addr kept", 32'(int_addr), 22);
    // Read back 20..24.
    drive(1'b0, 1'b1, 1'b0, 1'b0, 6'd20, 16'h0);
    tick();
    for (int k = 0; k < 5; k++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b0, 6'd0, 16'h0);
      tick();
      check("R10 rd_valid", 32'(rd_valid), 1);
      check("R9 R10 read data", 32'(rdata), 32'(16'hA000 + k));
    end
    drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 16'h0);
    tick();
    check("R10 rd_valid drops", 32'(rd_valid), 0);
  endtask

  task automatic t_alternate();
    // Fill 0..15 with 0x0100+address.
    drive(1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 16'h0);
    tick();
    for (int k = 0; k < 16; k++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b1, 6'd0, 16'(16'h0100 + k));
      tick();
    end
    // Load 2 then read on alternate cycles with counting on.
    drive(1'b0, 1'b0, 1'b0, 1'b0, 6'd2, 16'h0);
    tick();
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 16'h0);
      tick();
      drive(1'b1, 1'b0, 1'b1, 1'b0, 6'd0, 16'h0);
      tick();
      check("R11 rd_valid", 32'(rd_valid), 1);
      check("R11 alternate word", 32'(rdata), 32'(16'h0100 + 2 + 2*k + 1));
    end
    drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 16'h0);
    tick();
    check("R11 addr after burst", 32'(int_addr), 8);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load_step_hold();
    t_priority_wrap();
    t_ce_independent();
    t_write_read();
    t_alternate();
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule